// File: doc/BRIEF.md
# Modem Line Change Detector with Automatic DTR Pacing

This block watches four modem status lines (DSR, CTS, RI and CD) for one serial channel. Each line is brought into the clock domain through a two-stage synchroniser. A transition on a line is then compared against two per-line masks: one for falling edges and one for rising edges. An enabled transition sets a sticky per-line change flag. While any flag is set, the block holds its service request high. Software reads the flags and clears them by writing ones.

The block also paces the remote sender through DTR. A 4-bit threshold is compared against the receive FIFO fill count, which arrives on an input. When the FIFO holds more characters than the threshold, DTR drops. When the count falls back to the threshold or below, DTR rises again. A threshold of zero or an unusable code (13 to 15) hands DTR to a software bit. A configuration-error output warns when an active threshold is not above the receive service threshold.

The block has no data stream. Every pin is a plain control or status level, with no valid/ready handshake. Register writes take effect on the clock edge where `wr_en` is high. Register reads are combinational from `addr`.

Top module: `modem_watch`

## Requirements
- R1: After reset, every register reads 0x00, `svc_req`, `rts_o`, `dtr_o` and `cfg_err` are low, and `rdata` is 0x00 for addresses 0 and 1.
- R2: Address 2 reads the synchronised line levels in bits 7:4 (bit 7 DSR, bit 6 CTS, bit 5 RI, bit 4 CD), zeros in bits 3:1 and the RTS level in bit 0. A change on `modem_i` (bit 3 DSR, bit 2 CTS, bit 1 RI, bit 0 CD) shows there after exactly two rising clock edges.
- R3: Address 0 bits 7:4 enable one-to-zero detection per line, in the line order of R2. An enabled falling edge sets that line's flag on the third rising edge after the input changes.
- R4: Address 1 bits 7:4 enable zero-to-one detection per line, in the line order of R2. An enabled rising edge sets the line's flag with the same timing as R3. Bits 3:0 of address 1 always read zero.
- R5: A transition whose direction is not enabled for that line leaves its flag clear.
- R6: Address 3 bits 7:4 hold the change flags in the line order of R2. A flag stays set until a write to address 3 has a one in its bit. Writing a zero there leaves the flag unchanged.
- R7: `svc_req` is high exactly when at least one change flag is set.
- R8: With a threshold T (address 0 bits 3:0) in the range 1 to 12, `dtr_o` is low in the same cycle that `fifo_count` exceeds T, and high while `fifo_count` is T or less.
- R9: With T equal to 0 or 13 to 15, `dtr_o` equals address 3 bit 0, a read/write bit.
- R10: `cfg_err` is high exactly when T is in the range 1 to 12 and T is not larger than `rx_svc_thresh`.
- R11: Writing address 2 bit 0 sets `rts_o`. All other bits of that write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modem_i | input | 4 | Raw modem lines: DSR, CTS, RI, CD (bits 3..0) |
| fifo_count | input | CNT_W | Receive FIFO fill count |
| rx_svc_thresh | input | 4 | Receive FIFO service threshold |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| svc_req | output | 1 | Modem service request |
| dtr_o | output | 1 | DTR level, high means asserted |
| rts_o | output | 1 | RTS level |
| cfg_err | output | 1 | Active DTR threshold not above the service threshold |

## Verification
The bench drives random line patterns under random edge masks. It checks the flags one edge before and on the edge where they must appear. A design that tapped the synchroniser early, or dropped a stage, would show flags a cycle off. A design that swapped the falling and rising masks would flag the wrong lines.

Directed steps cover the following cases:
- A clear written in the same cycle as a new edge, where a wrong priority loses the event.
- A write of zeros to the flag register, which must not clear anything.
- FIFO counts exactly at the threshold and one above it, where an off-by-one comparison shows up.
- Threshold codes 13 to 15, which a careless decoder would treat as large thresholds instead of manual control.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned THR_W     = 4;
  localparam int unsigned MAX_THR   = 12;

  typedef enum logic [1:0] {
    ADDR_FALL_THR = 2'd0,
    ADDR_RISE     = 2'd1,
    ADDR_LEVELS   = 2'd2,
    ADDR_FLAGS    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/modem_edge_flags.sv
module modem_edge_flags #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] rise_en,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] hit,
  output logic [W-1:0] flags
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    logic fell, rose;
    assign fell   = prev_q[i] & ~level[i];
    assign rose   = ~prev_q[i] & level[i];
    assign hit[i] = (fell & fall_en[i]) | (rose & rise_en[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flags[i] <= 1'b0;
      else if (hit[i])         flags[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/modem_dtr_ctl.sv
module modem_dtr_ctl #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned THR_W   = 4,
  parameter int unsigned MAX_THR = 12
) (
  input  logic [THR_W-1:0] thr,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [THR_W-1:0] rx_svc_thresh,
  input  logic             man_dtr,
  output logic             auto_on,
  output logic             dtr,
  output logic             cfg_err
);
  localparam int unsigned CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] cnt_x, thr_x;

  assign cnt_x   = CMP_W'(fifo_count);
  assign thr_x   = CMP_W'(thr);
  assign auto_on = (thr != '0) && (thr <= THR_W'(MAX_THR));
  assign dtr     = auto_on ? (cnt_x <= thr_x) : man_dtr;
  assign cfg_err = auto_on && (thr <= rx_svc_thresh);
endmodule

// File: rtl/modem_watch.sv
module modem_watch
  import modem_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] modem_i,
  input  logic [CNT_W-1:0]     fifo_count,
  input  logic [THR_W-1:0]     rx_svc_thresh,
  input  logic                 wr_en,
  input  logic [1:0]           addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic                 svc_req,
  output logic                 dtr_o,
  output logic                 rts_o,
  output logic                 cfg_err
);
  logic [NUM_LINES-1:0] fall_en_q, rise_en_q, level, hit, flags;
  logic [THR_W-1:0]     thr_q;
  logic                 rts_q, man_dtr_q, auto_on, flag_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_en_q <= '0;
      thr_q     <= '0;
      rise_en_q <= '0;
      rts_q     <= 1'b0;
      man_dtr_q <= 1'b0;
    end else if (wr_en) begin
      unique case (reg_addr_e'(addr))
        ADDR_FALL_THR: begin
          fall_en_q <= wdata[7:4];
          thr_q     <= wdata[3:0];
        end
        ADDR_RISE:   rise_en_q <= wdata[7:4];
        ADDR_LEVELS: rts_q     <= wdata[0];
        ADDR_FLAGS:  man_dtr_q <= wdata[0];
        default: ;
      endcase
    end
  end

  assign flag_wr = wr_en && (reg_addr_e'(addr) == ADDR_FLAGS);

  modem_sync #(.W(NUM_LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(modem_i), .q(level)
  );

  modem_edge_flags #(.W(NUM_LINES)) u_edges (
    .clk(clk), .rst_n(rst_n), .level(level),
    .fall_en(fall_en_q), .rise_en(rise_en_q),
    .clr_we(flag_wr), .clr_mask(wdata[7:4]),
    .hit(hit), .flags(flags)
  );

  modem_dtr_ctl #(.CNT_W(CNT_W), .THR_W(THR_W), .MAX_THR(MAX_THR)) u_dtr (
    .thr(thr_q), .fifo_count(fifo_count), .rx_svc_thresh(rx_svc_thresh),
    .man_dtr(man_dtr_q), .auto_on(auto_on), .dtr(dtr_o), .cfg_err(cfg_err)
  );

  always_comb begin
    unique case (reg_addr_e'(addr))
      ADDR_FALL_THR: rdata = {fall_en_q, thr_q};
      ADDR_RISE:     rdata = {rise_en_q, 4'b0000};
      ADDR_LEVELS:   rdata = {level, 3'b000, rts_q};
      ADDR_FLAGS:    rdata = {flags, 3'b000, man_dtr_q};
      default:       rdata = 8'h00;
    endcase
  end

  assign svc_req = |flags;
  assign rts_o   = rts_q;
endmodule

// File: rtl/modem_watch_chk.sv
module modem_watch_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic             svc_req,
  input logic             dtr_o,
  input logic             cfg_err,
  input logic [CNT_W-1:0] fifo_count,
  input logic [3:0]       thr,
  input logic             man_dtr,
  input logic [3:0]       hit,
  input logic [3:0]       flags
);
  logic thr_live;
  assign thr_live = (thr >= 4'd1) && (thr <= 4'd12);

  AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_req) |-> $past(|hit)) else $error("flag without edge"); // R5

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags && !(wr_en && addr == 2'd3)) |=> (flags & $past(flags)) == $past(flags))
    else $error("flag lost"); // R6

  AST_REQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> (svc_req == (rdata[7:4] != 4'b0000)))
    else $error("request mismatch"); // R7

  AST_DTR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_live && ({1'b0, fifo_count} > (CNT_W+1)'(thr))) |-> !dtr_o)
    else $error("dtr held high"); // R8

  AST_DTR_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_live |-> (dtr_o == man_dtr)) else $error("manual dtr"); // R9

  AST_CFG_ERR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> thr_live) else $error("cfg_err with idle threshold"); // R10

  AST_RISE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd1) |-> (rdata[3:0] == 4'b0000)) else $error("rise reg low bits"); // R4

  AST_LEVEL_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd2) |-> (rdata[3:1] == 3'b000)) else $error("level pad bits"); // R2

  logic unused_ok;
  assign unused_ok = ^wdata;
endmodule

bind modem_watch modem_watch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .svc_req(svc_req), .dtr_o(dtr_o), .cfg_err(cfg_err),
  .fifo_count(fifo_count), .thr(thr_q), .man_dtr(man_dtr_q),
  .hit(hit), .flags(flags)
);

// File: tb/test_modem_watch.sv
`timescale 1ns/1ps
module test_modem_watch;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       modem_i = '0;
  logic [CNT_W-1:0] fifo_count = '0;
  logic [3:0]       rx_svc_thresh = '0;
  logic             wr_en = 1'b0;
  logic [1:0]       addr = '0;
  logic [7:0]       wdata = '0;
  logic [7:0]       rdata;
  logic             svc_req, dtr_o, rts_o, cfg_err;

  int total = 0;
  int bad = 0;
  logic man_m = 1'b0;

  always #2 clk = ~clk;

  modem_watch #(.CNT_W(CNT_W)) i_modem_watch (
    .clk(clk), .rst_n(rst_n), .modem_i(modem_i), .fifo_count(fifo_count),
    .rx_svc_thresh(rx_svc_thresh), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .svc_req(svc_req), .dtr_o(dtr_o), .rts_o(rts_o),
    .cfg_err(cfg_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  function automatic logic [3:0] exp_flags(logic [3:0] o, logic [3:0] n,
                                          logic [3:0] fe, logic [3:0] re);
    return ((o & ~n) & fe) | ((~o & n) & re);
  endfunction

  function automatic logic exp_dtr(logic [3:0] t, int cnt, logic man);
    if (t >= 4'd1 && t <= 4'd12) return cnt <= int'(t);
    return man;
  endfunction

  function automatic logic exp_err(logic [3:0] t, logic [3:0] s);
    return (t >= 4'd1 && t <= 4'd12) && (t <= s);
  endfunction

  task automatic wait_edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [3:0] cur;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 reg", d, 8'h00);
    end
    check("R1 svc_req", svc_req, 0);
    check("R1 rts/dtr/err", {rts_o, dtr_o, cfg_err}, 3'b000);

    // R11 RTS write, other bits ignored
    wr(2'd2, 8'hFF);
    check("R11 rts set", rts_o, 1);
    rd(2'd2, d);
    check("R11 level reg", d, 8'h01);
    check("R11 no flags", svc_req, 0);
    wr(2'd2, 8'h00);
    check("R11 rts clr", rts_o, 0);

    // R4 rise register low bits read zero
    wr(2'd1, 8'hAF);
    rd(2'd1, d);
    check("R4 rise readback", d, 8'hA0);

    // R2/R3/R4/R5/R6/R7 random line changes
    cur = 4'h0;
    for (int it = 0; it < 60; it++) begin
      logic [3:0] fe, re, nw, ef;
      fe = 4'($urandom); re = 4'($urandom);
      nw = 4'($urandom);
      if (nw == cur) nw = ~cur;
      wr(2'd0, {fe, 4'h0});
      wr(2'd1, {re, 4'h0});
      wr(2'd3, {4'hF, 3'b000, man_m});
      check("R6 cleared", svc_req, 0);
      ef = exp_flags(cur, nw, fe, re);
      @(negedge clk);
      modem_i = nw;
      wait_edges(2);
      rd(2'd2, d);
      check("R2 levels", d, {nw, 4'b0000});
      rd(2'd3, d);
      check("R3 R4 flags early", d[7:4], 4'h0);
      wait_edges(1);
      rd(2'd3, d);
      check("R3 R4 R5 flags", d[7:4], ef);
      check("R7 svc_req", svc_req, |ef);
      cur = nw;
    end

    // R6 write zero leaves flags, partial clear
    wr(2'd0, 8'hF0);
    wr(2'd3, 8'hF0);
    @(negedge clk); modem_i = 4'h0;
    wait_edges(3);
    wr(2'd3, 8'h00);
    rd(2'd3, d);
    check("R6 write zero keeps", d[7:4], cur);
    wr(2'd3, 8'h80);
    rd(2'd3, d);
    check("R6 partial clear", d[7:4], cur & 4'h7);

    // R6 set wins over clear in same cycle
    wr(2'd1, 8'hF0);
    wr(2'd3, 8'hF0);
    @(negedge clk); modem_i = 4'h1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    addr = 2'd3; wdata = 8'h10; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd3, d);
    check("R6 set beats clear", d[7:4], 4'h1);
    check("R7 req held", svc_req, 1);

    // R8 boundaries
    rx_svc_thresh = 4'd2;
    wr(2'd0, 8'h05);
    fifo_count = 5'd5; #0.5;
    check("R8 at threshold", dtr_o, 1);
    fifo_count = 5'd6; #0.5;
    check("R8 above threshold", dtr_o, 0);

    // R9 invalid codes go manual
    man_m = 1'b1;
    wr(2'd3, {4'h0, 3'b000, man_m});
    for (int t = 13; t < 16; t++) begin
      wr(2'd0, {4'h0, 4'(t)});
      fifo_count = 5'd31; #0.5;
      check("R9 invalid code manual", dtr_o, 1);
      check("R10 no err invalid", cfg_err, 0);
    end
    wr(2'd0, 8'h00);
    fifo_count = 5'd31; #0.5;
    check("R9 zero manual", dtr_o, 1);

    // R8 R9 R10 random
    for (int it = 0; it < 80; it++) begin
      logic [3:0] t, s;
      int cnt;
      t = 4'($urandom); s = 4'($urandom);
      cnt = int'($urandom_range(0, 31));
      man_m = 1'($urandom);
      wr(2'd3, {4'h0, 3'b000, man_m});
      wr(2'd0, {4'h0, t});
      rx_svc_thresh = s; fifo_count = cnt[CNT_W-1:0]; #0.5;
      check("R8 R9 dtr", dtr_o, exp_dtr(t, cnt, man_m));
      check("R10 cfg_err", cfg_err, exp_err(t, s));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule